// File: doc/BRIEF.md
# RV64 Compressed Instruction Expander

This combinational unit sits between instruction fetch and the main decoder of an RV64 core. It receives a 32-bit fetched word. When the two lowest bits mark the low halfword as a 16-bit compressed instruction, the unit rewrites that halfword into the equivalent full-width RV64I encoding. The downstream decoder therefore only ever sees base-format instructions. When the word is already a full-width instruction, it passes through untouched.

Alongside the rewritten word, the unit reports whether the input was compressed. Fetch uses this flag to advance the program counter by 2 instead of 4. The unit also raises an illegal flag for encodings it refuses to expand. These are the compressed floating-point loads and stores, the reserved slots, and the encodings whose field values are reserved. The unit covers the integer forms in all three compressed quadrants.

Top module: `rvc_expander`

## Requirements
- R1: A word whose bits [1:0] are 11 leaves the block unchanged, with the compressed flag low and the illegal flag low. Any other value of bits [1:0] raises the compressed flag.
- R2: The expansion is selected by bits [15:13] together with the quadrant in bits [1:0].
  - In quadrant 00, the stack-pointer add becomes `addi rd', x2, imm`, with the immediate a multiple of 4.
  - Word loads and stores use unsigned offsets scaled by 4.
  - Doubleword loads and stores use unsigned offsets scaled by 8.
  - Every 3-bit register field selects x8 to x15.
- R3: In quadrant 00, selector values 001, 100 and 101 are illegal. A stack-pointer add with a zero immediate is also illegal, and this includes the all-zero halfword.
- R4: In quadrant 01, the following use a sign-extended 6-bit immediate (bit 12 is the sign):
  - add-immediate, including the no-op;
  - add-immediate-word;
  - load-immediate, which becomes `addi rd, x0, imm`.
  Selector 011 with rd = x2 adjusts the stack pointer by a sign-extended multiple of 16. Any other rd gives LUI with a sign-extended 6-bit upper immediate.
- R5: In quadrant 01, selector 100 is the register-prime arithmetic group:
  - logical and arithmetic right shifts by a 6-bit amount;
  - AND-immediate;
  - SUB, XOR, OR and AND;
  - SUBW and ADDW.
  The two reserved word-op slots (bit 12 set, bits [6:5] = 1x) are illegal.
- R6: The compressed jump becomes JAL with rd = x0. The compressed zero-branches become BEQ or BNE of rs1' against x0. All these offsets are sign-extended and counted in halfwords.
- R7: In quadrant 01, three cases are illegal:
  - the stack-pointer adjust with a zero immediate;
  - LUI with a zero immediate;
  - add-immediate-word with rd = x0.
- R8: In quadrant 10:
  - the left shift uses a 6-bit amount;
  - stack-relative word loads and stores scale the offset by 4, doubleword ones by 8;
  - word and doubleword stack loads with rd = x0 are illegal;
  - selectors 001 and 101 are illegal.
- R9: Quadrant 10 selector 100 decodes as follows:

  | Bit 12 | rs1/rd | rs2 | Expansion |
  |---|---|---|---|
  | 0 | nonzero | 0 | `jalr x0, 0(rs1)` |
  | 0 | any | nonzero | `add rd, x0, rs2` |
  | 1 | 0 | 0 | EBREAK (32'h00100073) |
  | 1 | nonzero | 0 | `jalr x1, 0(rs1)` |
  | 1 | any | nonzero | `add rd, rd, rs2` |

  The jump-register form with rs1 = 0 is illegal.
- R10: With the default zero-fill option, an illegal compressed input drives the expanded output to 32'h0 while the compressed flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_word_i | input | 32 | Fetched instruction word; a compressed instruction occupies bits [15:0] |
| insn_o | output | 32 | Expanded or passed-through instruction |
| is_compressed_o | output | 1 | High when bits [1:0] of the input are not 11 |
| illegal_o | output | 1 | High when a compressed input has no supported expansion |

## Verification
The bench builds the expander with its defaults: a 32-bit word, a 16-bit compressed slot, and zero fill on illegal inputs. This makes the illegal-output value a fixed, checkable constant. Since the compressed space holds only 49152 halfwords, the bench drives every one of them, each with random upper bits. This reaches every reserved slot, every zero-immediate and zero-register corner, and every sign boundary of the branch and jump offsets. Random full-width words with bits [1:0] = 11 confirm pass-through, and a few hand-encoded words anchor the behavioural model to known encodings.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

   localparam logic [6:0] OPC_LOAD    = 7'b0000011;
   localparam logic [6:0] OPC_STORE   = 7'b0100011;
   localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
   localparam logic [6:0] OPC_OPIMM32 = 7'b0011011;
   localparam logic [6:0] OPC_OP      = 7'b0110011;
   localparam logic [6:0] OPC_OP32    = 7'b0111011;
   localparam logic [6:0] OPC_LUI     = 7'b0110111;
   localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
   localparam logic [6:0] OPC_JAL     = 7'b1101111;
   localparam logic [6:0] OPC_JALR    = 7'b1100111;
   localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;

   localparam logic [4:0] REG_ZERO = 5'd0;
   localparam logic [4:0] REG_RA   = 5'd1;
   localparam logic [4:0] REG_SP   = 5'd2;

   typedef enum logic [1:0] {
      QD0     = 2'b00,
      QD1     = 2'b01,
      QD2     = 2'b10,
      QD_FULL = 2'b11
   } quad_e;

   // 3-bit short register field -> x8..x15
   function automatic logic [4:0] prime_reg(input logic [2:0] r);
      return {2'b01, r};
   endfunction

   function automatic logic [31:0] fmt_r(input logic [6:0] f7, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [2:0] f3,
                                         input logic [4:0] rd, input logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] fmt_i(input logic [11:0] imm, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd,
                                         input logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] fmt_s(input logic [11:0] imm, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [2:0] f3,
                                         input logic [6:0] op);
      return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
   endfunction

   function automatic logic [31:0] fmt_b(input logic [12:0] imm, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [2:0] f3);
      return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
   endfunction

   function automatic logic [31:0] fmt_u(input logic [19:0] imm, input logic [4:0] rd,
                                         input logic [6:0] op);
      return {imm, rd, op};
   endfunction

   function automatic logic [31:0] fmt_j(input logic [20:0] imm, input logic [4:0] rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
   endfunction

endpackage

// File: rtl/rvc_q0_expand.sv
module rvc_q0_expand
   import rvc_pkg::*;
#(
   parameter int unsigned HW = 16
) (
   input  logic [HW-1:0] half_i,
   output logic [31:0]   word_o,
   output logic          bad_o
);

   localparam int unsigned SEL_LO = HW - 3;

   logic [2:0] sel;
   logic [4:0] rd_p;
   logic [4:0] rs1_p;
   logic [9:0] spn_imm;
   logic [6:0] w_off;
   logic [7:0] d_off;
   logic       unused_q0;

   assign sel       = half_i[HW-1:SEL_LO];
   assign rd_p      = prime_reg(half_i[4:2]);
   assign rs1_p     = prime_reg(half_i[9:7]);
   assign spn_imm   = {half_i[10:7], half_i[12:11], half_i[5], half_i[6], 2'b00};
   assign w_off     = {half_i[5], half_i[12:10], half_i[6], 2'b00};
   assign d_off     = {half_i[6:5], half_i[12:10], 3'b000};
   assign unused_q0 = ^half_i[1:0];

   always_comb begin
      word_o = '0;
      bad_o  = 1'b0;
      case (sel)
         3'b000: begin
            word_o = fmt_i({2'b00, spn_imm}, REG_SP, 3'b000, rd_p, OPC_OPIMM);
            bad_o  = (spn_imm == '0);
         end
         3'b010: word_o = fmt_i({5'b0, w_off}, rs1_p, 3'b010, rd_p, OPC_LOAD);
         3'b011: word_o = fmt_i({4'b0, d_off}, rs1_p, 3'b011, rd_p, OPC_LOAD);
         3'b110: word_o = fmt_s({5'b0, w_off}, rd_p, rs1_p, 3'b010, OPC_STORE);
         3'b111: word_o = fmt_s({4'b0, d_off}, rd_p, rs1_p, 3'b011, OPC_STORE);
         default: bad_o = 1'b1;
      endcase
   end

   always_comb begin
      if (!$isunknown(half_i)) begin
         // R2
         q0_opcode_chk: assert (bad_o || word_o[6:0] inside {OPC_OPIMM, OPC_LOAD, OPC_STORE});
      end
   end

endmodule

// File: rtl/rvc_q1_expand.sv
module rvc_q1_expand
   import rvc_pkg::*;
#(
   parameter int unsigned HW = 16
) (
   input  logic [HW-1:0] half_i,
   output logic [31:0]   word_o,
   output logic          bad_o
);

   localparam int unsigned SEL_LO = HW - 3;

   logic [2:0]  sel;
   logic [4:0]  rd;
   logic [4:0]  rd_p;
   logic [4:0]  rs2_p;
   logic [5:0]  imm6;
   logic [11:0] imm12;
   logic [9:0]  sp16;
   logic [11:0] sp_imm12;
   logic [19:0] lui20;
   logic [11:0] joff;
   logic [20:0] jimm21;
   logic [8:0]  boff;
   logic [12:0] bimm13;
   logic [31:0] alu_word;
   logic        alu_bad;
   logic        unused_q1;

   assign sel       = half_i[HW-1:SEL_LO];
   assign rd        = half_i[11:7];
   assign rd_p      = prime_reg(half_i[9:7]);
   assign rs2_p     = prime_reg(half_i[4:2]);
   assign imm6      = {half_i[12], half_i[6:2]};
   assign imm12     = {{6{imm6[5]}}, imm6};
   assign sp16      = {half_i[12], half_i[4:3], half_i[5], half_i[2], half_i[6], 4'b0000};
   assign sp_imm12  = {{2{sp16[9]}}, sp16};
   assign lui20     = {{14{imm6[5]}}, imm6};
   assign joff      = {half_i[12], half_i[8], half_i[10:9], half_i[6], half_i[7],
                       half_i[2], half_i[11], half_i[5:3], 1'b0};
   assign jimm21    = {{9{joff[11]}}, joff};
   assign boff      = {half_i[12], half_i[6:5], half_i[2], half_i[11:10], half_i[4:3], 1'b0};
   assign bimm13    = {{4{boff[8]}}, boff};
   assign unused_q1 = ^half_i[1:0];

   // register-prime arithmetic group
   always_comb begin
      alu_word = '0;
      alu_bad  = 1'b0;
      case (half_i[11:10])
         2'b00: alu_word = fmt_i({6'b000000, imm6}, rd_p, 3'b101, rd_p, OPC_OPIMM);
         2'b01: alu_word = fmt_i({6'b010000, imm6}, rd_p, 3'b101, rd_p, OPC_OPIMM);
         2'b10: alu_word = fmt_i(imm12, rd_p, 3'b111, rd_p, OPC_OPIMM);
         default: begin
            if (!half_i[12]) begin
               case (half_i[6:5])
                  2'b00:   alu_word = fmt_r(7'b0100000, rs2_p, rd_p, 3'b000, rd_p, OPC_OP);
                  2'b01:   alu_word = fmt_r(7'b0000000, rs2_p, rd_p, 3'b100, rd_p, OPC_OP);
                  2'b10:   alu_word = fmt_r(7'b0000000, rs2_p, rd_p, 3'b110, rd_p, OPC_OP);
                  default: alu_word = fmt_r(7'b0000000, rs2_p, rd_p, 3'b111, rd_p, OPC_OP);
               endcase
            end else begin
               case (half_i[6:5])
                  2'b00:   alu_word = fmt_r(7'b0100000, rs2_p, rd_p, 3'b000, rd_p, OPC_OP32);
                  2'b01:   alu_word = fmt_r(7'b0000000, rs2_p, rd_p, 3'b000, rd_p, OPC_OP32);
                  default: alu_bad  = 1'b1;
               endcase
            end
         end
      endcase
   end

   always_comb begin
      word_o = '0;
      bad_o  = 1'b0;
      case (sel)
         3'b000: word_o = fmt_i(imm12, rd, 3'b000, rd, OPC_OPIMM);
         3'b001: begin
            word_o = fmt_i(imm12, rd, 3'b000, rd, OPC_OPIMM32);
            bad_o  = (rd == REG_ZERO);
         end
         3'b010: word_o = fmt_i(imm12, REG_ZERO, 3'b000, rd, OPC_OPIMM);
         3'b011: begin
            if (rd == REG_SP) begin
               word_o = fmt_i(sp_imm12, REG_SP, 3'b000, REG_SP, OPC_OPIMM);
               bad_o  = (sp16 == '0);
            end else begin
               word_o = fmt_u(lui20, rd, OPC_LUI);
               bad_o  = (imm6 == '0);
            end
         end
         3'b100: begin
            word_o = alu_word;
            bad_o  = alu_bad;
         end
         3'b101:  word_o = fmt_j(jimm21, REG_ZERO);
         3'b110:  word_o = fmt_b(bimm13, REG_ZERO, rd_p, 3'b000);
         default: word_o = fmt_b(bimm13, REG_ZERO, rd_p, 3'b001);
      endcase
   end

   always_comb begin
      if (!$isunknown(half_i)) begin
         // R4
         q1_opcode_chk: assert (bad_o || word_o[6:0] inside
            {OPC_OPIMM, OPC_OPIMM32, OPC_LUI, OPC_OP, OPC_OP32, OPC_JAL, OPC_BRANCH});
      end
   end

endmodule

// File: rtl/rvc_q2_expand.sv
module rvc_q2_expand
   import rvc_pkg::*;
#(
   parameter int unsigned HW = 16
) (
   input  logic [HW-1:0] half_i,
   output logic [31:0]   word_o,
   output logic          bad_o
);

   localparam int unsigned SEL_LO = HW - 3;

   logic [2:0] sel;
   logic [4:0] rd;
   logic [4:0] rs2;
   logic [5:0] shamt;
   logic [7:0] lwsp;
   logic [8:0] ldsp;
   logic [7:0] swsp;
   logic [8:0] sdsp;
   logic       unused_q2;

   assign sel       = half_i[HW-1:SEL_LO];
   assign rd        = half_i[11:7];
   assign rs2       = half_i[6:2];
   assign shamt     = {half_i[12], half_i[6:2]};
   assign lwsp      = {half_i[3:2], half_i[12], half_i[6:4], 2'b00};
   assign ldsp      = {half_i[4:2], half_i[12], half_i[6:5], 3'b000};
   assign swsp      = {half_i[8:7], half_i[12:9], 2'b00};
   assign sdsp      = {half_i[9:7], half_i[12:10], 3'b000};
   assign unused_q2 = ^half_i[1:0];

   always_comb begin
      word_o = '0;
      bad_o  = 1'b0;
      case (sel)
         3'b000: word_o = fmt_i({6'b000000, shamt}, rd, 3'b001, rd, OPC_OPIMM);
         3'b010: begin
            word_o = fmt_i({4'b0, lwsp}, REG_SP, 3'b010, rd, OPC_LOAD);
            bad_o  = (rd == REG_ZERO);
         end
         3'b011: begin
            word_o = fmt_i({3'b0, ldsp}, REG_SP, 3'b011, rd, OPC_LOAD);
            bad_o  = (rd == REG_ZERO);
         end
         3'b100: begin
            if (!half_i[12]) begin
               if (rs2 == REG_ZERO) begin
                  word_o = fmt_i(12'd0, rd, 3'b000, REG_ZERO, OPC_JALR);
                  bad_o  = (rd == REG_ZERO);
               end else begin
                  word_o = fmt_r(7'd0, rs2, REG_ZERO, 3'b000, rd, OPC_OP);
               end
            end else begin
               if (rs2 == REG_ZERO && rd == REG_ZERO) begin
                  word_o = fmt_i(12'd1, REG_ZERO, 3'b000, REG_ZERO, OPC_SYSTEM);
               end else if (rs2 == REG_ZERO) begin
                  word_o = fmt_i(12'd0, rd, 3'b000, REG_RA, OPC_JALR);
               end else begin
                  word_o = fmt_r(7'd0, rs2, rd, 3'b000, rd, OPC_OP);
               end
            end
         end
         3'b110: word_o = fmt_s({4'b0, swsp}, rs2, REG_SP, 3'b010, OPC_STORE);
         3'b111: word_o = fmt_s({3'b0, sdsp}, rs2, REG_SP, 3'b011, OPC_STORE);
         default: bad_o = 1'b1;
      endcase
   end

   always_comb begin
      if (!$isunknown(half_i)) begin
         // R8
         q2_opcode_chk: assert (bad_o || word_o[6:0] inside
            {OPC_OPIMM, OPC_LOAD, OPC_STORE, OPC_JALR, OPC_OP, OPC_SYSTEM});
      end
   end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
   import rvc_pkg::*;
#(
   parameter int unsigned ILEN            = 32,
   parameter int unsigned CLEN            = 16,
   parameter bit          ZERO_ON_ILLEGAL = 1'b1
) (
   input  logic [ILEN-1:0] fetch_word_i,
   output logic [ILEN-1:0] insn_o,
   output logic            is_compressed_o,
   output logic            illegal_o
);

   localparam int unsigned QW     = 2;
   localparam int unsigned NQUAD  = (1 << QW) - 1;
   localparam int unsigned PAD_W  = ILEN - CLEN;

   if (ILEN != 32) begin : g_bad_ilen
      $error("rvc_expander: ILEN must be 32");
   end
   if (CLEN != 16) begin : g_bad_clen
      $error("rvc_expander: CLEN must be 16");
   end

   logic [CLEN-1:0] half;
   quad_e           quad;
   logic [31:0]     q_word [NQUAD];
   logic [NQUAD-1:0] q_bad;
   logic [31:0]     sel_word;
   logic            sel_bad;
   logic            is_c;

   assign half = fetch_word_i[CLEN-1:0];
   assign quad = quad_e'(half[QW-1:0]);

   for (genvar q = 0; q < NQUAD; q++) begin : g_quad
      if (q == 0) begin : g_q0
         rvc_q0_expand #(.HW(CLEN)) u_exp (.half_i(half), .word_o(q_word[q]), .bad_o(q_bad[q]));
      end else if (q == 1) begin : g_q1
         rvc_q1_expand #(.HW(CLEN)) u_exp (.half_i(half), .word_o(q_word[q]), .bad_o(q_bad[q]));
      end else begin : g_q2
         rvc_q2_expand #(.HW(CLEN)) u_exp (.half_i(half), .word_o(q_word[q]), .bad_o(q_bad[q]));
      end
   end

   always_comb begin
      sel_word = fetch_word_i;
      sel_bad  = 1'b0;
      is_c     = 1'b1;
      case (quad)
         QD0: begin sel_word = q_word[0]; sel_bad = q_bad[0]; end
         QD1: begin sel_word = q_word[1]; sel_bad = q_bad[1]; end
         QD2: begin sel_word = q_word[2]; sel_bad = q_bad[2]; end
         default: is_c = 1'b0;
      endcase
   end

   assign is_compressed_o = is_c;
   assign illegal_o       = sel_bad;

   if (ZERO_ON_ILLEGAL) begin : g_zero_fill
      assign insn_o = sel_bad ? '0 : sel_word;

      always_comb begin
         if (!$isunknown(fetch_word_i)) begin
            // R10
            illegal_zero_chk: assert (!illegal_o || (is_compressed_o && insn_o == '0));
         end
      end
   end else begin : g_raw_fill
      assign insn_o = sel_bad ? {{PAD_W{1'b0}}, half} : sel_word;
   end

   always_comb begin
      if (!$isunknown(fetch_word_i)) begin
         // R1
         passthrough_chk: assert (is_compressed_o || (insn_o == fetch_word_i && !illegal_o));
         // R2
         full_form_chk: assert (!is_compressed_o || illegal_o || insn_o[1:0] == 2'b11);
      end
   end

endmodule

// File: tb/sim_rvc_expander.sv
module sim_rvc_expander;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] stim;
   logic [31:0] insn;
   logic        is_c;
   logic        ill;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   rvc_expander u0 (
      .fetch_word_i   (stim),
      .insn_o         (insn),
      .is_compressed_o(is_c),
      .illegal_o      (ill)
   );

   function automatic int fld(input logic [15:0] h, input int hi, input int lo);
      return int'((h >> lo) & ((16'd1 << (hi - lo + 1)) - 16'd1));
   endfunction

   function automatic int sx(input int v, input int bits);
      return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
   endfunction

   function automatic logic [31:0] mk_i(input int imm, input int rs1, input int f3,
                                        input int rd, input int op);
      return 32'(((imm & 'hfff) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
   endfunction

   function automatic logic [31:0] mk_r(input int f7, input int rs2, input int rs1,
                                        input int f3, input int rd, input int op);
      return 32'((f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op);
   endfunction

   function automatic logic [31:0] mk_s(input int imm, input int rs2, input int rs1,
                                        input int f3, input int op);
      return 32'((((imm >> 5) & 'h7f) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12)
                 | ((imm & 31) << 7) | op);
   endfunction

   function automatic logic [31:0] mk_b(input int imm, input int rs1, input int f3);
      return 32'((((imm >> 12) & 1) << 31) | (((imm >> 5) & 63) << 25) | (rs1 << 15)
                 | (f3 << 12) | (((imm >> 1) & 15) << 8) | (((imm >> 11) & 1) << 7) | 'h63);
   endfunction

   function automatic logic [31:0] mk_j(input int imm, input int rd);
      return 32'((((imm >> 20) & 1) << 31) | (((imm >> 1) & 1023) << 21)
                 | (((imm >> 11) & 1) << 20) | (((imm >> 12) & 255) << 12) | (rd << 7) | 'h6f);
   endfunction

   // behavioural reference: expected word, compressed flag, illegal flag, requirement tag
   task automatic model(input logic [31:0] w, output logic [31:0] e, output logic c,
                        output logic bad, output string tag);
      logic [15:0] h;
      int q, f, r5, r2, pa, pb, k6, sh, u, s, o;
      h   = w[15:0];
      q   = fld(h, 1, 0);
      f   = fld(h, 15, 13);
      r5  = fld(h, 11, 7);
      r2  = fld(h, 6, 2);
      pa  = 8 + fld(h, 9, 7);
      pb  = 8 + fld(h, 4, 2);
      sh  = fld(h, 12, 12) * 32 + r2;
      k6  = sx(sh, 6);
      e   = '0;
      c   = 1'b1;
      bad = 1'b0;
      tag = "R1";
      if (q == 3) begin
         e = w;
         c = 1'b0;
      end else if (q == 0) begin
         tag = "R2";
         case (f)
            0: begin
               u = fld(h, 10, 7) * 64 + fld(h, 12, 11) * 16 + fld(h, 5, 5) * 8 + fld(h, 6, 6) * 4;
               if (u == 0) begin bad = 1'b1; tag = "R3"; end
               else e = mk_i(u, 2, 0, pb, 'h13);
            end
            2: e = mk_i(fld(h, 5, 5) * 64 + fld(h, 12, 10) * 8 + fld(h, 6, 6) * 4, pa, 2, pb, 3);
            3: e = mk_i(fld(h, 6, 5) * 64 + fld(h, 12, 10) * 8, pa, 3, pb, 3);
            6: e = mk_s(fld(h, 5, 5) * 64 + fld(h, 12, 10) * 8 + fld(h, 6, 6) * 4, pb, pa, 2, 'h23);
            7: e = mk_s(fld(h, 6, 5) * 64 + fld(h, 12, 10) * 8, pb, pa, 3, 'h23);
            default: begin bad = 1'b1; tag = "R3"; end
         endcase
      end else if (q == 1) begin
         tag = "R4";
         case (f)
            0: e = mk_i(k6, r5, 0, r5, 'h13);
            1: if (r5 == 0) begin bad = 1'b1; tag = "R7"; end
               else e = mk_i(k6, r5, 0, r5, 'h1b);
            2: e = mk_i(k6, 0, 0, r5, 'h13);
            3: if (r5 == 2) begin
                  s = sx(fld(h, 12, 12) * 512 + fld(h, 4, 3) * 128 + fld(h, 5, 5) * 64
                         + fld(h, 2, 2) * 32 + fld(h, 6, 6) * 16, 10);
                  if (s == 0) begin bad = 1'b1; tag = "R7"; end
                  else e = mk_i(s, 2, 0, 2, 'h13);
               end else begin
                  if (k6 == 0) begin bad = 1'b1; tag = "R7"; end
                  else e = 32'(((k6 & 'hfffff) << 12) | (r5 << 7) | 'h37);
               end
            4: begin
               tag = "R5";
               case (fld(h, 11, 10))
                  0: e = mk_i(sh, pa, 5, pa, 'h13);
                  1: e = mk_i(1024 + sh, pa, 5, pa, 'h13);
                  2: e = mk_i(k6, pa, 7, pa, 'h13);
                  default: begin
                     o = fld(h, 6, 5);
                     if (fld(h, 12, 12) == 0) begin
                        case (o)
                           0: e = mk_r(32, pb, pa, 0, pa, 'h33);
                           1: e = mk_r(0, pb, pa, 4, pa, 'h33);
                           2: e = mk_r(0, pb, pa, 6, pa, 'h33);
                           default: e = mk_r(0, pb, pa, 7, pa, 'h33);
                        endcase
                     end else if (o == 0) e = mk_r(32, pb, pa, 0, pa, 'h3b);
                     else if (o == 1) e = mk_r(0, pb, pa, 0, pa, 'h3b);
                     else bad = 1'b1;
                  end
               endcase
            end
            5: begin
               tag = "R6";
               s = sx(fld(h, 12, 12) * 2048 + fld(h, 8, 8) * 1024 + fld(h, 10, 9) * 256
                      + fld(h, 6, 6) * 128 + fld(h, 7, 7) * 64 + fld(h, 2, 2) * 32
                      + fld(h, 11, 11) * 16 + fld(h, 5, 3) * 2, 12);
               e = mk_j(s, 0);
            end
            default: begin
               tag = "R6";
               s = sx(fld(h, 12, 12) * 256 + fld(h, 6, 5) * 64 + fld(h, 2, 2) * 32
                      + fld(h, 11, 10) * 8 + fld(h, 4, 3) * 2, 9);
               e = mk_b(s, pa, (f == 6) ? 0 : 1);
            end
         endcase
      end else begin
         tag = "R8";
         case (f)
            0: e = mk_i(sh, r5, 1, r5, 'h13);
            2: if (r5 == 0) bad = 1'b1;
               else e = mk_i(fld(h, 3, 2) * 64 + fld(h, 12, 12) * 32 + fld(h, 6, 4) * 4, 2, 2, r5, 3);
            3: if (r5 == 0) bad = 1'b1;
               else e = mk_i(fld(h, 4, 2) * 64 + fld(h, 12, 12) * 32 + fld(h, 6, 5) * 8, 2, 3, r5, 3);
            4: begin
               tag = "R9";
               if (fld(h, 12, 12) == 0) begin
                  if (r2 == 0) begin
                     if (r5 == 0) bad = 1'b1;
                     else e = mk_i(0, r5, 0, 0, 'h67);
                  end else e = mk_r(0, r2, 0, 0, r5, 'h33);
               end else begin
                  if (r2 == 0 && r5 == 0) e = 32'h0010_0073;
                  else if (r2 == 0) e = mk_i(0, r5, 0, 1, 'h67);
                  else e = mk_r(0, r2, r5, 0, r5, 'h33);
               end
            end
            6: e = mk_s(fld(h, 8, 7) * 64 + fld(h, 12, 9) * 4, r2, 2, 2, 'h23);
            7: e = mk_s(fld(h, 9, 7) * 64 + fld(h, 12, 10) * 8, r2, 2, 3, 'h23);
            default: bad = 1'b1;
         endcase
      end
      if (bad) e = '0;
   endtask

   task automatic compare(input string tag, input logic [31:0] e, input logic ec, input logic eb);
      n_vec++;
      if (insn !== e || is_c !== ec || ill !== eb) begin
         n_bad++;
         $display("FAIL %s in=%h got insn=%h c=%b ill=%b exp insn=%h c=%b ill=%b",
                  tag, stim, insn, is_c, ill, e, ec, eb);
      end
   endtask

   task automatic apply_known(input logic [31:0] w, input logic [31:0] e, input logic ec,
                              input logic eb, input string tag);
      @(posedge clk);
      #1 stim = w;
      @(negedge clk);
      compare(tag, e, ec, eb);
   endtask

   task automatic apply_model(input logic [31:0] w);
      logic [31:0] e;
      logic        ec, eb;
      string       tag;
      @(posedge clk);
      #1 stim = w;
      model(w, e, ec, eb, tag);
      @(negedge clk);
      compare(tag, e, ec, eb);
   endtask

   initial begin
      stim  = 32'h0000_0013;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 reset", 32'h0000_0013, 1'b0, 1'b0);
      apply_known(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 all-ones");
      apply_known(32'h0000_0001, 32'h0000_0013, 1'b1, 1'b0, "R4 nop");
      apply_known(32'h0000_4501, 32'h0000_0513, 1'b1, 1'b0, "R4 li");
      apply_known(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R3 R10 zero half");
      apply_known(32'hABCD_9002, 32'h0010_0073, 1'b1, 1'b0, "R9 ebreak");
      apply_known(32'h1234_8082, 32'h0000_8067, 1'b1, 1'b0, "R9 jr ra");
      for (int i = 0; i < 65536; i++) begin
         if (i[1:0] != 2'b11) apply_model({$urandom_range(0, 65535), i[15:0]});
      end
      for (int i = 0; i < 1000; i++) apply_model($urandom | 32'h3);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired after %0d vectors, expected completion", n_vec);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule